// File: doc/BRIEF.md
# Nonlinear Combination Random Bit Generator

This block produces a pseudo-random bit stream that a linear solver cannot recover from a short observation. Three small maximal-length shift registers with feedback run side by side, each of a different length. On every clock all three step once. The most significant bit of each register feeds a nonlinear three-input function, and the result is the output bit. An N-bit linear register alone gives away its whole future after about 2N observed bits. The nonlinear merge removes that shortcut.

A seed bus and a load strobe restart all three registers from a common value. Seeds that would leave a register at zero are fixed up to 1, so the registers cannot lock up. A registered word output carries the XOR of two of the register states for consumers that want a wide value every cycle. The register lengths are 5, 7 and 3. Their periods of 31, 127 and 7 are pairwise coprime, so the merged stream repeats only after 27559 clocks.

Top module: `nlc_rng`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, every register holds the value 1, `rnd_bit` is 0 and `rnd_word` is 0, and the outputs take these values without waiting for a clock edge.
- R2: On each rising edge without a load, each register shifts one place toward its MSB, and its new bit 0 is the XOR of its tapped bits. The register's output bit is its MSB. The taps are: A (5 bits, x^5+x^3+1) bits 4 and 2; B (7 bits, x^7+x^6+1) bits 6 and 5; C (3 bits, x^3+x^2+1) bits 2 and 1.
- R3: `rnd_bit` equals (a AND b) XOR (b AND c) XOR c, where a, b and c are the current MSBs of A, B and C. It is valid in the same cycle as the state it comes from.
- R4: When `seed_load` is high at an edge, each register takes `seed[W-1:0]` for its width W and ignores the higher seed bits. Loading takes precedence over stepping, so while the strobe stays high the seeded value is held.
- R5: When the low W bits of the seed are all zero for a register, that register loads 1 instead of 0.
- R6: At every edge, `rnd_word` captures the XOR of register B and register C, each zero-extended to 32 bits. The value therefore appears one clock after the state it comes from.
- R7: No register ever holds zero. The periods are 31, 127 and 7, so `rnd_bit` repeats with a period of 27559 clocks.
- R8: Over any 27559 consecutive steps without a load, `rnd_bit` is 1 exactly 14980 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Loads the seed into all three registers at the next edge |
| seed | input | 32 | Shared seed value |
| rnd_bit | output | 1 | Nonlinear combination of the three register MSBs |
| rnd_word | output | 32 | Registered XOR of registers B and C |

## Verification
After a rising edge, `rnd_bit` reflects the new register state in that same cycle. `rnd_word` carries the state from before that edge, so it is one clock behind. The bench changes its inputs and samples both outputs at the falling edge. It keeps a model whose word term is computed from the pre-edge state before the model registers step, which matches the output's one-cycle lag. The reset check samples one time unit after `rst_n` falls in the middle of a cycle, so it observes the asynchronous clear before any clock edge can occur.

// File: rtl/nlc_pkg.sv
package nlc_pkg;

  // Nonlinear merge of the three register output bits.
  function automatic logic nlc_combine(input logic a, input logic b, input logic c);
    return (a & b) ^ (b & c) ^ c;
  endfunction

  // One Fibonacci step: shift toward the MSB, parity of tapped bits enters at bit 0.
  function automatic logic nlc_parity(input logic [63:0] bits);
    return ^bits;
  endfunction

endpackage

// File: rtl/nlc_lfsr.sv
module nlc_lfsr #(
  parameter int          W      = 5,
  parameter logic [W-1:0] TAPS  = 5'b10100,
  parameter int          SEED_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEED_W-1:0] seed,
  output logic [W-1:0]      state,
  output logic              msb,
  output logic              seed_fixed
);
  import nlc_pkg::*;

  localparam int FIT_W = (W < SEED_W) ? W : SEED_W;

  logic [W-1:0] state_q;
  logic [W-1:0] seed_fit;
  logic [W-1:0] seed_val;
  logic [W-1:0] step_nx;
  logic         feedback;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_fit
      if (gi < FIT_W) begin : g_take
        assign seed_fit[gi] = seed[gi];
      end else begin : g_clear
        assign seed_fit[gi] = 1'b0;
      end
    end
    if (SEED_W > W) begin : g_drop
      logic unused_seed_hi;
      assign unused_seed_hi = ^seed[SEED_W-1:W];
    end
  endgenerate

  assign seed_fixed = ~|seed_fit;
  assign seed_val   = seed_fixed ? W'(1) : seed_fit;
  assign feedback   = nlc_parity(64'(state_q & TAPS));
  assign step_nx    = {state_q[W-2:0], feedback};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W'(1);
    end else if (load) begin
      state_q <= seed_val;
    end else begin
      state_q <= step_nx;
    end
  end

  assign state = state_q;
  assign msb   = state_q[W-1];

endmodule

// File: rtl/nlc_word_mix.sv
module nlc_word_mix #(
  parameter int WORD_W = 32,
  parameter int X_W    = 7,
  parameter int Y_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [X_W-1:0]    x,
  input  logic [Y_W-1:0]    y,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] mix_nx;
  logic [WORD_W-1:0] word_q;

  genvar gi;
  generate
    for (gi = 0; gi < WORD_W; gi++) begin : g_bit
      logic xb, yb;
      if (gi < X_W) begin : g_x
        assign xb = x[gi];
      end else begin : g_xz
        assign xb = 1'b0;
      end
      if (gi < Y_W) begin : g_y
        assign yb = y[gi];
      end else begin : g_yz
        assign yb = 1'b0;
      end
      assign mix_nx[gi] = xb ^ yb;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= mix_nx;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/nlc_rng.sv
module nlc_rng #(
  parameter int             WORD_W = 32,
  parameter int             SEED_W = 32,
  parameter int             A_W    = 5,
  parameter logic [A_W-1:0] A_TAPS = 5'b10100,
  parameter int             B_W    = 7,
  parameter logic [B_W-1:0] B_TAPS = 7'b1100000,
  parameter int             C_W    = 3,
  parameter logic [C_W-1:0] C_TAPS = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [SEED_W-1:0] seed,
  output logic              rnd_bit,
  output logic [WORD_W-1:0] rnd_word
);
  import nlc_pkg::*;

  logic [A_W-1:0] a_state;
  logic [B_W-1:0] b_state;
  logic [C_W-1:0] c_state;
  logic a_msb, b_msb, c_msb;
  logic a_fix, b_fix, c_fix;
  logic any_fix;

  nlc_lfsr #(.W(A_W), .TAPS(A_TAPS), .SEED_W(SEED_W)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed),
    .state(a_state), .msb(a_msb), .seed_fixed(a_fix)
  );

  nlc_lfsr #(.W(B_W), .TAPS(B_TAPS), .SEED_W(SEED_W)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed),
    .state(b_state), .msb(b_msb), .seed_fixed(b_fix)
  );

  nlc_lfsr #(.W(C_W), .TAPS(C_TAPS), .SEED_W(SEED_W)) u_reg_c (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed),
    .state(c_state), .msb(c_msb), .seed_fixed(c_fix)
  );

  // Named event: some register would have been seeded to zero.
  logic unused_any_fix;
  assign any_fix        = a_fix | b_fix | c_fix;
  assign unused_any_fix = any_fix;

  assign rnd_bit = nlc_combine(a_msb, b_msb, c_msb);

  nlc_word_mix #(.WORD_W(WORD_W), .X_W(B_W), .Y_W(C_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .x(b_state), .y(c_state), .word(rnd_word)
  );

endmodule

// File: rtl/nlc_rng_checker.sv
module nlc_rng_checker #(
  parameter int SEED_W = 32,
  parameter int A_W    = 5,
  parameter int B_W    = 7,
  parameter int C_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seed_load,
  input logic [SEED_W-1:0] seed,
  input logic              rnd_word_lsb,
  input logic [A_W-1:0]    a_state,
  input logic [B_W-1:0]    b_state,
  input logic [C_W-1:0]    c_state
);

  assert_shift_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load |=> a_state[A_W-1:1] == $past(a_state[A_W-2:0]));

  assert_shift_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load |=> b_state[B_W-1:1] == $past(b_state[B_W-2:0]));

  assert_never_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_state != '0) && (b_state != '0) && (c_state != '0));

  assert_load_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed[0]) |=> (a_state[0] && b_state[0] && c_state[0]));

  assert_zero_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed == '0) |=>
      (a_state == A_W'(1)) && (b_state == B_W'(1)) && (c_state == C_W'(1)));

  assert_word_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_word_lsb == ($past(b_state[0]) ^ $past(c_state[0])));

endmodule

bind nlc_rng nlc_rng_checker #(
  .SEED_W(SEED_W), .A_W(A_W), .B_W(B_W), .C_W(C_W)
) u_nlc_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
  .rnd_word_lsb(rnd_word[0]), .a_state(a_state), .b_state(b_state), .c_state(c_state)
);

// File: tb/test_nlc_rng.sv
module test_nlc_rng;
  localparam int PERIOD = 27559;
  localparam int ONES   = 14980;
  localparam int NVEC   = 6;
  localparam logic [31:0] SEEDS [NVEC] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'hA5A5_5A5A,
                                          32'h0000_0060, 32'h0000_0000, 32'h8000_0000};
  localparam int STEPS [NVEC] = '{40, 40, 40, 40, 40, 40};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_load = 1'b0;
  logic [31:0] seed = '0;
  logic        rnd_bit;
  logic [31:0] rnd_word;

  always #4 clk = ~clk;

  nlc_rng i_nlc_rng (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
    .rnd_bit(rnd_bit), .rnd_word(rnd_word)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0]  ma;
  logic [6:0]  mb;
  logic [2:0]  mc;
  logic [31:0] mword;

  function automatic logic mdl_bit();
    return mc[2] ? (ma[4] | ~mb[6]) : (ma[4] & mb[6]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdl_reset();
    ma = 5'd1; mb = 7'd1; mc = 3'd1; mword = '0;
  endtask

  task automatic mdl_edge(input bit ld, input logic [31:0] sd);
    mword = {25'b0, mb} ^ {29'b0, mc};
    if (ld) begin
      ma = (sd[4:0] == 0) ? 5'd1 : sd[4:0];
      mb = (sd[6:0] == 0) ? 7'd1 : sd[6:0];
      mc = (sd[2:0] == 0) ? 3'd1 : sd[2:0];
    end else begin
      ma = {ma[3:0], ma[4] ^ ma[2]};
      mb = {mb[5:0], mb[6] ^ mb[5]};
      mc = {mc[1:0], mc[2] ^ mc[1]};
    end
  endtask

  task automatic tick(input bit ld, input logic [31:0] sd);
    seed_load = ld;
    seed = sd;
    @(posedge clk);
    mdl_edge(ld, sd);
    @(negedge clk);
    seed_load = 1'b0;
  endtask

  task automatic cmp(input string req);
    chk(rnd_bit == mdl_bit(), req, 32'(rnd_bit), 32'(mdl_bit()));
    chk(rnd_word == mword, "R6 word", rnd_word, mword);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int ones;
    int mism;
    logic [63:0] first_bits;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rnd_bit == 1'b0, "R1 bit in reset", 32'(rnd_bit), 32'd0);
    chk(rnd_word == '0, "R1 word in reset", rnd_word, 32'd0);
    rst_n = 1'b1;
    mdl_reset();
    for (int k = 0; k < 10; k++) begin
      tick(1'b0, '0);
      cmp("R2 R3 free run after reset");
    end

    // Table walk: load each seed, then step and compare to the model
    for (int v = 0; v < NVEC; v++) begin
      tick(1'b1, SEEDS[v]);
      cmp("R4 R5 after load");
      for (int s = 0; s < STEPS[v]; s++) begin
        tick(1'b0, '0);
        cmp("R2 R3 stepping");
      end
    end

    // R4: all-ones seed, hand-computed values
    tick(1'b1, 32'hFFFF_FFFF);
    chk(rnd_bit == 1'b1, "R4 all-ones load bit", 32'(rnd_bit), 32'd1);
    tick(1'b0, '0);
    chk(rnd_word == 32'h0000_0078, "R4 R6 word from all-ones seed", rnd_word, 32'h78);

    // R5: seed 0x08 leaves C zero, forced to 1
    tick(1'b1, 32'h0000_0008);
    chk(rnd_bit == 1'b0, "R5 bit after fix-up load", 32'(rnd_bit), 32'd0);
    tick(1'b0, '0);
    chk(rnd_word == 32'h0000_0009, "R5 word shows forced C", rnd_word, 32'h9);

    // R4: held load keeps the seeded value
    tick(1'b1, 32'h0000_005A);
    tick(1'b1, 32'h0000_005A);
    chk(rnd_word == 32'h0000_0058, "R4 held load word", rnd_word, 32'h58);
    tick(1'b1, 32'h0000_005A);
    chk(rnd_word == 32'h0000_0058, "R4 held load stays", rnd_word, 32'h58);
    cmp("R4 held load model");

    // R7 R8: full combined period from seed 1
    tick(1'b1, 32'h0000_0001);
    ones = 0;
    mism = 0;
    first_bits = '0;
    for (int t = 0; t < PERIOD; t++) begin
      tick(1'b0, '0);
      if (rnd_bit) ones++;
      if (rnd_bit != mdl_bit() || rnd_word != mword) mism++;
      if (t < 64) first_bits[t] = rnd_bit;
    end
    chk(mism == 0, "R7 model agreement over period", 32'(mism), 32'd0);
    chk(ones == ONES, "R8 ones over combined period", 32'(ones), 32'(ONES));
    mism = 0;
    for (int t = 0; t < 64; t++) begin
      tick(1'b0, '0);
      if (rnd_bit != first_bits[t]) mism++;
    end
    chk(mism == 0, "R7 stream repeats after 27559", 32'(mism), 32'd0);

    // R1: asynchronous reset in mid-cycle
    chk(rnd_word != '0, "R1 precondition word nonzero", rnd_word, 32'd1);
    #1 rst_n = 1'b0;
    #1;
    chk(rnd_word == '0, "R1 async clear word", rnd_word, 32'd0);
    chk(rnd_bit == 1'b0, "R1 async clear bit", 32'(rnd_bit), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mdl_reset();
    tick(1'b0, '0);
    cmp("R1 R2 restart after reset");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule